// File: doc/BRIEF.md
# Three-Port Multicast Frame Crossbar with Deficit Round Robin

This block switches frames between three input streams and three output streams. In the intended use, two inputs come from the network receive side and one from host software. Two outputs feed the network transmit side and one feeds the host. Each frame opens with a 128-bit header word. Three bits of that word form a destination mask, and the frame is copied to every output the mask names. A frame with an empty mask is consumed and discarded.

Every input/output pair owns a private frame buffer, giving nine buffers in all. A frame becomes eligible for an output only after its last beat has been stored. Each output runs its own deficit round robin arbiter over the three buffers that feed it. The arbiter counts in bytes, and the length of the frame at the head of a buffer is known before transmission starts. An output sends complete frames back to back and never mixes beats of two frames.

The input side stalls a beat whenever any buffer that the frame targets is full. A frame must therefore fit in one buffer (at most `DEPTH` beats), because a partly stored frame is never forwarded.

Top module: `drr_xbar`

## Requirements
- R1: For three cycles after reset is released, and while no input is valid, every `out_valid` bit is 0 and every `in_ready` bit is 1.
- R2: Bits [2:0] of a frame's first beat form the destination mask, and bit o selects output o. A frame with one mask bit set leaves only that output. Its beats, data, start and end flags are unchanged, and the byte count of its last beat (1 to 16) is unchanged. The frame length is 16 times (beats minus 1) plus that count.
- R3: A frame with several mask bits set is delivered as an identical copy on each selected output.
- R4: A frame whose mask is 000 is accepted without any stall and produces nothing on any output.
- R5: An input beat is accepted only when every buffer its frame targets has room. Otherwise `in_ready` stays low and no targeted output sees that frame until room appears.
- R6: Each output sends whole frames. After a first beat, the following beats come from the same frame without gaps up to its end beat. While `out_ready` is low, `out_valid` and the beat stay unchanged.
- R7: Each output keeps a byte deficit per input and visits inputs in the order 0, 1, 2. On a visit to a buffer holding a complete frame, it adds `QUANTUM` (default 64) once. It then sends head frames while their length does not exceed the deficit, subtracting each length, and moves on after that.
- R8: When an output visits a buffer that holds no complete frame, the deficit for that buffer is set to zero, so unused credit is not carried forward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Datapath clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 3 | Beat valid per input |
| in_ready | output | 3 | Beat accepted per input when high together with valid |
| in_sof | input | 3 | First beat of a frame per input |
| in_eof | input | 3 | Last beat of a frame per input |
| in_bytes | input | 15 | Valid byte count of the last beat, 5 bits per input |
| in_data | input | 384 | Beat data, 128 bits per input, mask in bits [2:0] of the first beat |
| out_valid | output | 3 | Beat valid per output |
| out_ready | input | 3 | Downstream can take a beat, per output |
| out_sof | output | 3 | First beat of a frame per output |
| out_eof | output | 3 | Last beat of a frame per output |
| out_bytes | output | 15 | Valid byte count of the last beat, 5 bits per output |
| out_data | output | 384 | Beat data, 128 bits per output |

## Verification
Assertions watch on every cycle that no buffer is written when full or read when empty. They also check that an output beat is held under back-pressure, that a started frame continues without gap or a new start, that deficits stay within their bound, and that a deficit is zero after a visit to a buffer with no complete frame. Only the directed scenarios can show which outputs a mask reaches, that dropped frames vanish without stalls, and that a blocked buffer holds back a multicast frame. They also show the exact serving order that deficit round robin produces under mixed frame lengths. The clearing of unused credit is made visible through the order in a second contended round.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

  typedef enum logic {
    ARB_PICK = 1'b0,
    ARB_SEND = 1'b1
  } arb_state_e;

endpackage

// File: rtl/xbar_fifo.sv
module xbar_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             full,
  output logic             empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0]    cnt_q, cnt_d;

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    if (push) wp_d = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (pop)  rp_d = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
  end

  assign rdata = mem[rp_q];
  assign full  = (cnt_q == CW'(DEPTH));
  assign empty = (cnt_q == '0);

  // R5: the ingress gate must never write into a full buffer
  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);

  // R6: an arbiter must never read a buffer that holds nothing
  assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

endmodule

// File: rtl/xbar_ingress.sv
module xbar_ingress #(
  parameter int N         = 3,
  parameter int CNT_W     = 5,
  parameter int LEN_W     = 9,
  parameter int BYTES_PER = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [CNT_W-1:0] in_bytes,
  input  logic [N-1:0]     hdr_mask,
  input  logic [N-1:0]     buf_space,
  output logic             in_ready,
  output logic [N-1:0]     push,
  output logic [LEN_W-1:0] frame_len
);

  logic [N-1:0]     mask_q, mask_cur;
  logic [LEN_W-1:0] acc_q, acc_cur, acc_nxt;
  logic             take;

  always_comb begin
    mask_cur  = in_sof ? hdr_mask : mask_q;
    acc_cur   = in_sof ? '0 : acc_q;
    in_ready  = &(~mask_cur | buf_space);
    take      = in_valid & in_ready;
    push      = take ? mask_cur : '0;
    frame_len = acc_cur + LEN_W'(in_bytes);
    acc_nxt   = in_eof ? '0 : acc_cur + LEN_W'(BYTES_PER);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      acc_q  <= '0;
    end else if (take) begin
      mask_q <= mask_cur;
      acc_q  <= acc_nxt;
    end
  end

endmodule

// File: rtl/xbar_drr.sv
module xbar_drr
  import xbar_pkg::*;
#(
  parameter int N       = 3,
  parameter int BEAT_W  = 135,
  parameter int LEN_W   = 9,
  parameter int DEF_W   = 9,
  parameter int QUANTUM = 64,
  parameter int MAX_LEN = 256
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      has_frame,
  input  logic [LEN_W-1:0]  head_len [N],
  input  logic [N-1:0]      beat_avail,
  input  logic [BEAT_W-1:0] beat_data [N],
  input  logic              out_ready,
  output logic [N-1:0]      len_pop,
  output logic [N-1:0]      beat_pop,
  output logic              out_valid,
  output logic [BEAT_W-1:0] out_beat
);

  localparam int PW      = (N > 1) ? $clog2(N) : 1;
  localparam int SOF_BIT = BEAT_W - 1;
  localparam int EOF_BIT = BEAT_W - 2;

  arb_state_e       state_q, state_d;
  logic [PW-1:0]    ptr_q, ptr_d, ptr_nxt;
  logic             topped_q, topped_d;
  logic [DEF_W-1:0] def_q [N];
  logic [DEF_W-1:0] def_d [N];
  logic [DEF_W-1:0] def_cur, len_cur;

  always_comb begin
    ptr_nxt   = (ptr_q == PW'(N - 1)) ? '0 : ptr_q + 1'b1;
    def_cur   = def_q[ptr_q];
    len_cur   = DEF_W'(head_len[ptr_q]);
    state_d   = state_q;
    ptr_d     = ptr_q;
    topped_d  = topped_q;
    def_d     = def_q;
    len_pop   = '0;
    beat_pop  = '0;
    out_valid = 1'b0;
    out_beat  = beat_data[ptr_q];
    case (state_q)
      ARB_PICK: begin
        if (!has_frame[ptr_q]) begin
          def_d[ptr_q] = '0;
          ptr_d        = ptr_nxt;
          topped_d     = 1'b0;
        end else if (len_cur <= def_cur) begin
          def_d[ptr_q]   = def_cur - len_cur;
          len_pop[ptr_q] = 1'b1;
          state_d        = ARB_SEND;
        end else if (!topped_q) begin
          def_d[ptr_q] = def_cur + DEF_W'(QUANTUM);
          topped_d     = 1'b1;
        end else begin
          ptr_d    = ptr_nxt;
          topped_d = 1'b0;
        end
      end
      ARB_SEND: begin
        out_valid = beat_avail[ptr_q];
        if (out_valid && out_ready) begin
          beat_pop[ptr_q] = 1'b1;
          if (out_beat[EOF_BIT]) state_d = ARB_PICK;
        end
      end
      default: state_d = ARB_PICK;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ARB_PICK;
      ptr_q    <= '0;
      topped_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      ptr_q    <= ptr_d;
      topped_q <= topped_d;
    end
  end

  for (genvar k = 0; k < N; k++) begin : g_def
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) def_q[k] <= '0;
      else        def_q[k] <= def_d[k];
    end

    // R7: a deficit never grows past one quantum above the longest frame
    assert_deficit_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
      def_q[k] < DEF_W'(QUANTUM + MAX_LEN));
  end

  // R6: a started frame continues on the next cycle with no new start
  assert_frame_contig_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !out_beat[EOF_BIT]) |=> (out_valid && !out_beat[SOF_BIT]));

  // R6: back-pressure holds the presented beat
  assert_hold_beat_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_beat)));

  // R8: visiting a buffer without a complete frame leaves its deficit at zero
  assert_deficit_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ARB_PICK && !has_frame[ptr_q]) |=> (def_q[$past(ptr_q)] == '0));

endmodule

// File: rtl/drr_xbar.sv
module drr_xbar #(
  parameter int NPORT    = 3,
  parameter int DATA_W   = 128,
  parameter int CNT_W    = $clog2(DATA_W / 8) + 1,
  parameter int DEPTH    = 16,
  parameter int QUANTUM  = 64,
  parameter int MASK_LSB = 0
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NPORT-1:0]          in_valid,
  output logic [NPORT-1:0]          in_ready,
  input  logic [NPORT-1:0]          in_sof,
  input  logic [NPORT-1:0]          in_eof,
  input  logic [NPORT*CNT_W-1:0]    in_bytes,
  input  logic [NPORT*DATA_W-1:0]   in_data,
  output logic [NPORT-1:0]          out_valid,
  input  logic [NPORT-1:0]          out_ready,
  output logic [NPORT-1:0]          out_sof,
  output logic [NPORT-1:0]          out_eof,
  output logic [NPORT*CNT_W-1:0]    out_bytes,
  output logic [NPORT*DATA_W-1:0]   out_data
);

  localparam int BYTES_PER = DATA_W / 8;
  localparam int MAX_LEN   = DEPTH * BYTES_PER;
  localparam int LEN_W     = $clog2(MAX_LEN + 1);
  localparam int DEF_W     = $clog2(QUANTUM + MAX_LEN + 1);
  localparam int BEAT_W    = DATA_W + CNT_W + 2;
  localparam int NBUF      = NPORT * NPORT;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic [NPORT-1:0]  ing_mask  [NPORT];
  logic [NPORT-1:0]  ing_space [NPORT];
  logic [NPORT-1:0]  ing_push  [NPORT];
  logic [LEN_W-1:0]  ing_len   [NPORT];

  logic [NBUF-1:0]   b_push, b_pop, b_full, b_empty;
  logic [NBUF-1:0]   l_push, l_pop, l_full, l_empty;
  logic [BEAT_W-1:0] b_wdata [NBUF];
  logic [BEAT_W-1:0] b_rdata [NBUF];
  logic [LEN_W-1:0]  l_rdata [NBUF];

  logic [NPORT-1:0]  arb_has   [NPORT];
  logic [NPORT-1:0]  arb_avail [NPORT];
  logic [NPORT-1:0]  arb_lpop  [NPORT];
  logic [NPORT-1:0]  arb_bpop  [NPORT];
  logic [LEN_W-1:0]  arb_hlen  [NPORT][NPORT];
  logic [BEAT_W-1:0] arb_beat  [NPORT][NPORT];
  logic [BEAT_W-1:0] arb_out   [NPORT];

  for (genvar i = 0; i < NPORT; i++) begin : g_in
    assign ing_mask[i] = in_data[i*DATA_W + MASK_LSB +: NPORT];

    xbar_ingress #(
      .N(NPORT), .CNT_W(CNT_W), .LEN_W(LEN_W), .BYTES_PER(BYTES_PER)
    ) u_ing (
      .clk       (clk),
      .rst_n     (rst_int_n),
      .in_valid  (in_valid[i]),
      .in_sof    (in_sof[i]),
      .in_eof    (in_eof[i]),
      .in_bytes  (in_bytes[i*CNT_W +: CNT_W]),
      .hdr_mask  (ing_mask[i]),
      .buf_space (ing_space[i]),
      .in_ready  (in_ready[i]),
      .push      (ing_push[i]),
      .frame_len (ing_len[i])
    );

    for (genvar o = 0; o < NPORT; o++) begin : g_x
      localparam int B = i * NPORT + o;

      assign ing_space[i][o] = ~b_full[B] & ~l_full[B];
      assign b_push[B]  = ing_push[i][o];
      assign l_push[B]  = ing_push[i][o] & in_eof[i];
      assign b_wdata[B] = {in_sof[i], in_eof[i], in_bytes[i*CNT_W +: CNT_W],
                           in_data[i*DATA_W +: DATA_W]};
      assign b_pop[B]   = arb_bpop[o][i];
      assign l_pop[B]   = arb_lpop[o][i];

      assign arb_has[o][i]   = ~l_empty[B];
      assign arb_avail[o][i] = ~b_empty[B];
      assign arb_hlen[o][i]  = l_rdata[B];
      assign arb_beat[o][i]  = b_rdata[B];

      xbar_fifo #(.WIDTH(BEAT_W), .DEPTH(DEPTH)) u_beat (
        .clk(clk), .rst_n(rst_int_n),
        .push(b_push[B]), .wdata(b_wdata[B]), .pop(b_pop[B]),
        .rdata(b_rdata[B]), .full(b_full[B]), .empty(b_empty[B])
      );

      xbar_fifo #(.WIDTH(LEN_W), .DEPTH(DEPTH)) u_len (
        .clk(clk), .rst_n(rst_int_n),
        .push(l_push[B]), .wdata(ing_len[i]), .pop(l_pop[B]),
        .rdata(l_rdata[B]), .full(l_full[B]), .empty(l_empty[B])
      );
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_out
    xbar_drr #(
      .N(NPORT), .BEAT_W(BEAT_W), .LEN_W(LEN_W), .DEF_W(DEF_W),
      .QUANTUM(QUANTUM), .MAX_LEN(MAX_LEN)
    ) u_arb (
      .clk        (clk),
      .rst_n      (rst_int_n),
      .has_frame  (arb_has[o]),
      .head_len   (arb_hlen[o]),
      .beat_avail (arb_avail[o]),
      .beat_data  (arb_beat[o]),
      .out_ready  (out_ready[o]),
      .len_pop    (arb_lpop[o]),
      .beat_pop   (arb_bpop[o]),
      .out_valid  (out_valid[o]),
      .out_beat   (arb_out[o])
    );

    assign out_sof[o]                     = arb_out[o][BEAT_W-1];
    assign out_eof[o]                     = arb_out[o][BEAT_W-2];
    assign out_bytes[o*CNT_W +: CNT_W]    = arb_out[o][DATA_W +: CNT_W];
    assign out_data[o*DATA_W +: DATA_W]   = arb_out[o][DATA_W-1:0];
  end

endmodule

// File: tb/drr_xbar_tb_top.sv
`timescale 1ns/1ps
module drr_xbar_tb_top;

  logic         clk;
  logic         rst_n;
  logic [2:0]   in_valid, in_ready, in_sof, in_eof;
  logic [14:0]  in_bytes;
  logic [383:0] in_data;
  logic [2:0]   out_valid, out_sof, out_eof;
  logic [2:0]   o_ready;
  logic [14:0]  out_bytes;
  logic [383:0] out_data;

  logic         tb_valid [3];
  logic         tb_sof   [3];
  logic         tb_eof   [3];
  logic [4:0]   tb_bytes [3];
  logic [127:0] tb_data  [3];

  int errors, checks;
  int stalls [3];
  int rx_cnt [3];
  int rx_src [3][32];
  int rx_seq [3][32];
  int rx_len [3][32];
  int m_idx  [3];
  bit m_bad  [3];
  bit async_done;

  assign in_valid = {tb_valid[2], tb_valid[1], tb_valid[0]};
  assign in_sof   = {tb_sof[2], tb_sof[1], tb_sof[0]};
  assign in_eof   = {tb_eof[2], tb_eof[1], tb_eof[0]};
  assign in_bytes = {tb_bytes[2], tb_bytes[1], tb_bytes[0]};
  assign in_data  = {tb_data[2], tb_data[1], tb_data[0]};

  drr_xbar dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_sof(in_sof), .in_eof(in_eof),
    .in_bytes(in_bytes), .in_data(in_data),
    .out_valid(out_valid), .out_ready(o_ready), .out_sof(out_sof), .out_eof(out_eof),
    .out_bytes(out_bytes), .out_data(out_data)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // output monitor: checks beat order and integrity, records whole frames (R6)
  always @(negedge clk) begin
    if (rst_n) begin
      for (int o = 0; o < 3; o++) begin
        if (out_valid[o] && o_ready[o]) begin
          logic [127:0] d;
          d = out_data[o*128 +: 128];
          if (int'(d[23:16]) != m_idx[o]) m_bad[o] = 1'b1;
          if (out_sof[o] != (m_idx[o] == 0)) m_bad[o] = 1'b1;
          if (d[63:32] != ~d[31:0]) m_bad[o] = 1'b1;
          if (out_eof[o] != (int'(d[23:16]) == int'(d[31:24]) - 1)) m_bad[o] = 1'b1;
          if (out_eof[o]) begin
            checks++;
            if (m_bad[o]) begin
              errors++;
              $display("FAIL R6 frame integrity on output %0d: actual=1 expected=0", o);
            end
            if (rx_cnt[o] < 32) begin
              rx_src[o][rx_cnt[o]] = int'(d[7:4]);
              rx_seq[o][rx_cnt[o]] = int'(d[15:8]);
              rx_len[o][rx_cnt[o]] = m_idx[o] * 16 + int'(out_bytes[o*5 +: 5]);
            end
            rx_cnt[o]++;
            m_idx[o] = 0;
            m_bad[o] = 1'b0;
          end else begin
            m_idx[o]++;
          end
        end
      end
    end
  end

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic clear_rx();
    for (int o = 0; o < 3; o++) begin
      rx_cnt[o] = 0;
      stalls[o] = 0;
    end
  endtask

  task automatic send_frame(input int p, input logic [2:0] mask, input int seq,
                            input int nb, input int lastb);
    for (int b = 0; b < nb; b++) begin
      logic [127:0] d;
      d = '0;
      d[2:0]   = mask;
      d[7:4]   = 4'(p);
      d[15:8]  = 8'(seq);
      d[23:16] = 8'(b);
      d[31:24] = 8'(nb);
      d[63:32] = ~d[31:0];
      tb_data[p]  = d;
      tb_valid[p] = 1'b1;
      tb_sof[p]   = (b == 0);
      tb_eof[p]   = (b == nb - 1);
      tb_bytes[p] = (b == nb - 1) ? 5'(lastb) : 5'd16;
      forever begin
        @(negedge clk);
        if (in_ready[p]) break;
        stalls[p]++;
      end
      @(posedge clk);
      #1;
    end
    tb_valid[p] = 1'b0;
    tb_sof[p]   = 1'b0;
    tb_eof[p]   = 1'b0;
  endtask

  task automatic exp_frame(input string req, input int o, input int k,
                           input int src, input int seq, input int len);
    chk(req, $sformatf("out%0d frame%0d source", o, k), rx_src[o][k], src);
    chk(req, $sformatf("out%0d frame%0d sequence", o, k), rx_seq[o][k], seq);
    chk(req, $sformatf("out%0d frame%0d length", o, k), rx_len[o][k], len);
  endtask

  task automatic t_reset();
    idle(3);
    chk("R1", "in_ready after reset", int'(in_ready), 7);
    chk("R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_unicast();
    clear_rx();
    send_frame(0, 3'b010, 10, 3, 5);
    idle(20);
    chk("R2", "out1 frame count", rx_cnt[1], 1);
    chk("R2", "out0 frame count", rx_cnt[0], 0);
    chk("R2", "out2 frame count", rx_cnt[2], 0);
    exp_frame("R2", 1, 0, 0, 10, 37);
  endtask

  task automatic t_multicast();
    clear_rx();
    send_frame(2, 3'b111, 11, 2, 16);
    idle(20);
    for (int o = 0; o < 3; o++) begin
      chk("R3", $sformatf("out%0d frame count", o), rx_cnt[o], 1);
      exp_frame("R3", o, 0, 2, 11, 32);
    end
  endtask

  task automatic t_drop();
    clear_rx();
    send_frame(1, 3'b000, 12, 5, 9);
    idle(20);
    chk("R4", "stall cycles on dropped frame", stalls[1], 0);
    chk("R4", "frames emitted for empty mask", rx_cnt[0] + rx_cnt[1] + rx_cnt[2], 0);
  endtask

  task automatic t_backpressure();
    clear_rx();
    o_ready = 3'b110;
    for (int s = 20; s < 24; s++) send_frame(0, 3'b001, s, 4, 16);
    async_done = 1'b0;
    fork
      begin
        send_frame(0, 3'b011, 24, 2, 16);
        async_done = 1'b1;
      end
    join_none
    idle(10);
    chk("R5", "in_ready[0] with full target buffer", int'(in_ready[0]), 0);
    chk("R5", "out1 frames while blocked", rx_cnt[1], 0);
    o_ready = 3'b111;
    wait (async_done);
    idle(60);
    chk("R5", "out0 frame count after release", rx_cnt[0], 5);
    for (int k = 0; k < 5; k++)
      chk("R5", $sformatf("out0 frame%0d sequence", k), rx_seq[0][k], 20 + k);
    chk("R5", "out1 frame count after release", rx_cnt[1], 1);
    chk("R5", "out1 sequence", rx_seq[1][0], 24);
  endtask

  task automatic t_contention();
    int seen;
    clear_rx();
    fork
      send_frame(0, 3'b001, 30, 4, 16);
      send_frame(1, 3'b001, 31, 4, 16);
      send_frame(2, 3'b001, 32, 4, 16);
    join
    idle(60);
    chk("R6", "out0 frames under contention", rx_cnt[0], 3);
    seen = 0;
    for (int k = 0; k < 3; k++) seen |= (1 << rx_src[0][k]);
    chk("R6", "sources served once each", seen, 7);
  endtask

  task automatic t_drr_order();
    clear_rx();
    o_ready = 3'b110;
    idle(10);
    send_frame(0, 3'b001, 1, 4, 16);
    send_frame(0, 3'b001, 2, 4, 16);
    send_frame(0, 3'b001, 3, 4, 16);
    send_frame(1, 3'b001, 4, 8, 16);
    send_frame(1, 3'b001, 5, 1, 16);
    idle(5);
    o_ready = 3'b111;
    idle(100);
    chk("R7", "out0 frame count", rx_cnt[0], 5);
    exp_frame("R7", 0, 0, 0, 1, 64);
    exp_frame("R7", 0, 1, 0, 2, 64);
    exp_frame("R7", 0, 2, 1, 4, 128);
    exp_frame("R7", 0, 3, 0, 3, 64);
    exp_frame("R7", 0, 4, 1, 5, 16);
  endtask

  task automatic t_deficit_clear();
    clear_rx();
    o_ready = 3'b110;
    idle(10);
    send_frame(0, 3'b001, 6, 4, 16);
    send_frame(1, 3'b001, 7, 7, 16);
    send_frame(0, 3'b001, 8, 4, 16);
    idle(5);
    o_ready = 3'b111;
    idle(100);
    chk("R8", "out0 frame count", rx_cnt[0], 3);
    exp_frame("R8", 0, 0, 0, 6, 64);
    exp_frame("R8", 0, 1, 0, 8, 64);
    exp_frame("R8", 0, 2, 1, 7, 112);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    errors = 0;
    checks = 0;
    o_ready = 3'b111;
    for (int p = 0; p < 3; p++) begin
      tb_valid[p] = 1'b0;
      tb_sof[p]   = 1'b0;
      tb_eof[p]   = 1'b0;
      tb_bytes[p] = '0;
      tb_data[p]  = '0;
      m_idx[p]    = 0;
      m_bad[p]    = 1'b0;
    end
    clear_rx();
    rst_n = 1'b0;
    idle(5);
    rst_n = 1'b1;
    t_reset();
    t_unicast();
    t_multicast();
    t_drop();
    t_backpressure();
    t_contention();
    t_drr_order();
    t_deficit_clear();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule